// File: doc/BRIEF.md
# Paged Memory Window Address Translator

This block sits between a host memory bus and a 16-bit memory card. It maps host addresses onto the card's 64 MB space through five programmable windows. One shared page byte must match host address bits 31..24 before any window can respond. This places all windows together in one of 256 16 MB regions. Inside that region, each window covers an inclusive range of 4 KB blocks, set by a 12-bit start and a 12-bit stop value compared against host bits 23..12. Each window also adds a 14-bit offset in 4 KB units to form the card address. The offset's high byte carries a write-protect bit and a bit that selects attribute or common card memory.

Software programs the windows one byte at a time through a byte-wide port. Any register can be read back at once. The host side presents one request per cycle as an address and a read/write flag. The result appears one clock later:
- a hit indication and the winning window number;
- the translated card address and the memory-space select;
- a write-permitted flag;
- for a write, either a card write strobe or a blocked indication.

A five-state machine holds the outcome of the last request:
- `ST_IDLE` means no request was made.
- `ST_MISS` means no window hit.
- `ST_READ` means a read hit.
- `ST_WRITE` means a write hit an unprotected window.
- `ST_DENY` means a write hit a protected window.

Every state moves to a next state on every clock, taken only from the request of that cycle:
- `T_NOREQ`: `req_valid` low leads to `ST_IDLE`.
- `T_NOHIT`: a request that hits no window leads to `ST_MISS`.
- `T_RDHIT`: a read hit leads to `ST_READ`.
- `T_WRHIT`: a write hit on an unprotected window leads to `ST_WRITE`.
- `T_WRPROT`: a write hit on a protected window leads to `ST_DENY`.

Top module: `pmw_translator`

## Requirements
- R1: After reset every register byte reads 00h, every window is disabled, and a request to any address misses.
- R2: Register map. Window w (0..4) owns byte addresses 8w..8w+7, and the page register is at byte address 40.
  - +0 holds start bits 7..0.
  - +1 holds the enable at bit 7 and start bits 11..8 at bits 3..0.
  - +2 holds stop bits 7..0.
  - +3 holds stop bits 11..8 at bits 3..0.
  - +4 holds offset bits 7..0.
  - +5 holds write-protect at bit 7, attribute select at bit 6 and offset bits 13..8 at bits 5..0.
  - Bytes +6, +7, addresses 41..63 and the bits not listed read 0, and writes to them have no effect.
  - `cfg_rdata` shows the byte at `cfg_addr` combinationally. A write takes effect at the clock edge.
- R3: A window can hit only when `req_addr[31:24]` equals the page register.
- R4: A window hits when its enable bit is 1 and `req_addr[23:12]` lies between its start and stop values, both limits included.
- R5: On a hit, `rsp_card_addr` equals (`req_addr` + offset × 4096) mod 2^26.
- R6: On a hit, `rsp_attr` equals the winning window's attribute select bit (1 = attribute memory, 0 = common memory).
- R7: On a hit, `rsp_wr_ok` is the inverse of the window's write-protect bit. A write that hits a protected window raises `rsp_wr_blocked` and produces no `card_we`.
- R8: When several windows hit, the lowest-numbered one wins. Its number appears on `rsp_win`.
- R9: Each response appears one clock after the request is sampled, with `rsp_valid` high for exactly that cycle. On a miss or with no request, `rsp_hit`, `rsp_win`, `rsp_card_addr`, `rsp_attr`, `rsp_wr_ok`, `rsp_wr_blocked` and `card_we` are all 0.
- R10: `card_we` is high for one cycle, only in response to a write that hits an unprotected window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register byte write enable |
| cfg_addr | input | 6 | Register byte address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data at `cfg_addr` |
| req_valid | input | 1 | Host request present this cycle |
| req_write | input | 1 | Request is a write |
| req_addr | input | 32 | Host byte address |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | A window hit |
| rsp_win | output | 3 | Number of the winning window |
| rsp_card_addr | output | 26 | Translated card address |
| rsp_attr | output | 1 | 1 = attribute memory, 0 = common memory |
| rsp_wr_ok | output | 1 | The hit window permits writes |
| rsp_wr_blocked | output | 1 | The write was refused by write protect |
| card_we | output | 1 | Card write strobe |

## Verification
Every response output is registered once, so its value is due on the first rising edge after the request is driven. The register readback is combinational, so it reflects a write at the edge that takes the write. The bench changes inputs a few nanoseconds after an edge. At each edge it first computes the expected response from its own register image, using the request held over that edge, and only then applies any register write to the image. It compares all outputs two nanoseconds after the edge, so a request and a register write in the same cycle see the old window settings.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
    localparam int HOST_AW       = 32;
    localparam int CARD_AW       = 26;
    localparam int PAGE_W        = 8;
    localparam int BND_W         = 12;
    localparam int OFS_W         = 14;
    localparam int CFG_AW        = 6;
    localparam int CFG_DW        = 8;
    localparam int BYTES_PER_WIN = 8;
    localparam int MAX_WIN       = 5;
    localparam int PAGE_LSB      = HOST_AW - PAGE_W;   // 24
    localparam int BND_LSB       = PAGE_LSB - BND_W;   // 12

    typedef struct packed {
        logic              en;
        logic              wp;
        logic              attr;
        logic [BND_W-1:0]  start;
        logic [BND_W-1:0]  stop;
        logic [OFS_W-1:0]  ofs;
    } win_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MISS,
        ST_READ,
        ST_WRITE,
        ST_DENY
    } xl_state_e;
endpackage

// File: rtl/pmw_regfile.sv
module pmw_regfile
    import pmw_pkg::*;
#(
    parameter int NUM_WIN = MAX_WIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  logic [CFG_DW-1:0] wdata,
    output logic [CFG_DW-1:0] rdata,
    output win_cfg_t          win_cfg [NUM_WIN],
    output logic [PAGE_W-1:0] page
);
    localparam int BSEL_W   = $clog2(BYTES_PER_WIN);
    localparam int IDX_W    = CFG_AW - BSEL_W;
    localparam int PAGE_IDX = NUM_WIN * BYTES_PER_WIN;
    localparam int BND_HI   = BND_W - CFG_DW;
    localparam int OFS_HI   = OFS_W - CFG_DW;

    logic [IDX_W-1:0]  widx;
    logic [BSEL_W-1:0] bsel;

    assign widx = addr[CFG_AW-1:BSEL_W];
    assign bsel = addr[BSEL_W-1:0];

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_cfg[g] <= '0;
            end else if (we && widx == IDX_W'(g)) begin
                case (bsel)
                    BSEL_W'(0): win_cfg[g].start[CFG_DW-1:0] <= wdata;
                    BSEL_W'(1): begin
                        win_cfg[g].en                 <= wdata[CFG_DW-1];
                        win_cfg[g].start[BND_W-1:CFG_DW] <= wdata[BND_HI-1:0];
                    end
                    BSEL_W'(2): win_cfg[g].stop[CFG_DW-1:0] <= wdata;
                    BSEL_W'(3): win_cfg[g].stop[BND_W-1:CFG_DW] <= wdata[BND_HI-1:0];
                    BSEL_W'(4): win_cfg[g].ofs[CFG_DW-1:0] <= wdata;
                    BSEL_W'(5): begin
                        win_cfg[g].wp                  <= wdata[CFG_DW-1];
                        win_cfg[g].attr                <= wdata[CFG_DW-2];
                        win_cfg[g].ofs[OFS_W-1:CFG_DW] <= wdata[OFS_HI-1:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page <= '0;
        end else if (we && addr == CFG_AW'(PAGE_IDX)) begin
            page <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (int'(widx) == w) begin
                case (bsel)
                    BSEL_W'(0): rdata = win_cfg[w].start[CFG_DW-1:0];
                    BSEL_W'(1): rdata = {win_cfg[w].en, {(CFG_DW-1-BND_HI){1'b0}},
                                         win_cfg[w].start[BND_W-1:CFG_DW]};
                    BSEL_W'(2): rdata = win_cfg[w].stop[CFG_DW-1:0];
                    BSEL_W'(3): rdata = {{(CFG_DW-BND_HI){1'b0}},
                                         win_cfg[w].stop[BND_W-1:CFG_DW]};
                    BSEL_W'(4): rdata = win_cfg[w].ofs[CFG_DW-1:0];
                    BSEL_W'(5): rdata = {win_cfg[w].wp, win_cfg[w].attr,
                                         win_cfg[w].ofs[OFS_W-1:CFG_DW]};
                    default:    rdata = '0;
                endcase
            end
        end
        if (addr == CFG_AW'(PAGE_IDX)) begin
            rdata = page;
        end
    end
endmodule

// File: rtl/pmw_win_match.sv
module pmw_win_match
    import pmw_pkg::*;
(
    input  win_cfg_t           cfg,
    input  logic [PAGE_W-1:0]  page,
    input  logic [HOST_AW-1:0] host_addr,
    output logic               hit,
    output logic [CARD_AW-1:0] card_addr
);
    logic [BND_W-1:0] blk;
    logic             page_eq;
    logic             in_range;

    assign blk       = host_addr[PAGE_LSB-1:BND_LSB];
    assign page_eq   = (host_addr[HOST_AW-1:PAGE_LSB] == page);
    assign in_range  = (blk >= cfg.start) && (blk <= cfg.stop);
    assign hit       = cfg.en && page_eq && in_range;
    assign card_addr = host_addr[CARD_AW-1:0] + {cfg.ofs, {BND_LSB{1'b0}}};
endmodule

// File: rtl/pmw_prio_sel.sv
module pmw_prio_sel #(
    parameter int NUM_WIN = 5,
    localparam int IW = $clog2(NUM_WIN)
) (
    input  logic [NUM_WIN-1:0] hits,
    output logic               any,
    output logic [IW-1:0]      idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hits[w]) begin
                any = 1'b1;
                idx = IW'(w);
            end
        end
    end
endmodule

// File: rtl/pmw_translator.sv
module pmw_translator #(
    parameter int NUM_WIN = pmw_pkg::MAX_WIN
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [pmw_pkg::CFG_AW-1:0]   cfg_addr,
    input  logic [pmw_pkg::CFG_DW-1:0]   cfg_wdata,
    output logic [pmw_pkg::CFG_DW-1:0]   cfg_rdata,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic [pmw_pkg::HOST_AW-1:0]  req_addr,
    output logic                         rsp_valid,
    output logic                         rsp_hit,
    output logic [$clog2(NUM_WIN)-1:0]   rsp_win,
    output logic [pmw_pkg::CARD_AW-1:0]  rsp_card_addr,
    output logic                         rsp_attr,
    output logic                         rsp_wr_ok,
    output logic                         rsp_wr_blocked,
    output logic                         card_we
);
    import pmw_pkg::*;
    localparam int WIN_IW = $clog2(NUM_WIN);

    win_cfg_t           win_cfg [NUM_WIN];
    logic [PAGE_W-1:0]  page_q;
    logic [NUM_WIN-1:0] win_hit;
    logic [CARD_AW-1:0] win_card [NUM_WIN];
    logic               any_hit;
    logic [WIN_IW-1:0]  sel_idx;
    logic               sel_wp;

    xl_state_e          state_q, state_d;
    logic [CARD_AW-1:0] card_q;
    logic               attr_q;
    logic               wp_q;
    logic [WIN_IW-1:0]  win_q;

    pmw_regfile #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .win_cfg (win_cfg),
        .page    (page_q)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
        pmw_win_match u_match (
            .cfg       (win_cfg[g]),
            .page      (page_q),
            .host_addr (req_addr),
            .hit       (win_hit[g]),
            .card_addr (win_card[g])
        );
    end

    pmw_prio_sel #(.NUM_WIN(NUM_WIN)) u_prio (
        .hits (win_hit),
        .any  (any_hit),
        .idx  (sel_idx)
    );

    assign sel_wp = win_cfg[sel_idx].wp;

    // Transitions are taken from every state on the current request alone.
    always_comb begin
        if (!req_valid)     state_d = ST_IDLE;   // T_NOREQ
        else if (!any_hit)  state_d = ST_MISS;   // T_NOHIT
        else if (!req_write) state_d = ST_READ;  // T_RDHIT
        else if (sel_wp)    state_d = ST_DENY;   // T_WRPROT
        else                state_d = ST_WRITE;  // T_WRHIT
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            card_q  <= '0;
            attr_q  <= 1'b0;
            wp_q    <= 1'b0;
            win_q   <= '0;
        end else begin
            state_q <= state_d;
            card_q  <= win_card[sel_idx];
            attr_q  <= win_cfg[sel_idx].attr;
            wp_q    <= sel_wp;
            win_q   <= sel_idx;
        end
    end

    always_comb begin
        rsp_valid      = 1'b0;
        rsp_hit        = 1'b0;
        rsp_win        = '0;
        rsp_card_addr  = '0;
        rsp_attr       = 1'b0;
        rsp_wr_ok      = 1'b0;
        rsp_wr_blocked = 1'b0;
        card_we        = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_MISS: rsp_valid = 1'b1;
            ST_READ: begin
                rsp_valid     = 1'b1;
                rsp_hit       = 1'b1;
                rsp_win       = win_q;
                rsp_card_addr = card_q;
                rsp_attr      = attr_q;
                rsp_wr_ok     = !wp_q;
            end
            ST_WRITE: begin
                rsp_valid     = 1'b1;
                rsp_hit       = 1'b1;
                rsp_win       = win_q;
                rsp_card_addr = card_q;
                rsp_attr      = attr_q;
                rsp_wr_ok     = 1'b1;
                card_we       = 1'b1;
            end
            ST_DENY: begin
                rsp_valid      = 1'b1;
                rsp_hit        = 1'b1;
                rsp_win        = win_q;
                rsp_card_addr  = card_q;
                rsp_attr       = attr_q;
                rsp_wr_blocked = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pmw_translator_chk.sv
module pmw_translator_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [7:0]  req_page,
    input logic [7:0]  page_q,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic        rsp_wr_ok,
    input logic        rsp_wr_blocked,
    input logic        card_we,
    input logic [25:0] rsp_card_addr
);
    p_resp_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rsp_valid == $past(req_valid));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_hit && !card_we && !rsp_wr_blocked);

    p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> rsp_card_addr == '0 && !rsp_wr_ok);

    p_page_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> $past(req_page) == $past(page_q));

    p_hit_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> $past(req_valid));

    p_block_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr_blocked |-> !card_we && !rsp_wr_ok && $past(req_write));

    p_strobe_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        card_we |-> $past(req_valid) && $past(req_write) && rsp_wr_ok);
endmodule

bind pmw_translator pmw_translator_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_page       (req_addr[31:24]),
    .page_q         (page_q),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_wr_ok      (rsp_wr_ok),
    .rsp_wr_blocked (rsp_wr_blocked),
    .card_we        (card_we),
    .rsp_card_addr  (rsp_card_addr)
);

// File: tb/pmw_translator_bench.sv
module pmw_translator_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_attr, rsp_wr_ok, rsp_wr_blocked, card_we;
    logic [2:0]  rsp_win;
    logic [25:0] rsp_card_addr;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;
    logic [7:0] mregs [64];

    always #10 clk = ~clk;

    pmw_translator u_pmw_translator (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_win(rsp_win), .rsp_card_addr(rsp_card_addr),
        .rsp_attr(rsp_attr), .rsp_wr_ok(rsp_wr_ok),
        .rsp_wr_blocked(rsp_wr_blocked), .card_we(card_we)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Writable-bit mask per byte address (R2 map).
    function automatic logic [7:0] wmask(input int a);
        if (a == 40) return 8'hFF;
        if (a >= 40) return 8'h00;
        case (a % 8)
            0, 2, 4, 5: return 8'hFF;
            1:          return 8'h8F;
            3:          return 8'h0F;
            default:    return 8'h00;
        endcase
    endfunction

    // One clock: reference model at the edge, compare 2 ns later.
    task automatic tick();
        int  win;
        bit  e_valid, e_hit, e_attr, e_ok, e_blk, e_we;
        int  e_win;
        longint e_card;
        @(posedge clk);
        e_valid = req_valid; e_hit = 0; e_attr = 0; e_ok = 0; e_blk = 0; e_we = 0;
        e_win = 0; e_card = 0; win = -1;
        if (req_valid) begin
            for (int w = 4; w >= 0; w--) begin
                int st, sp, blk;
                st  = {mregs[w*8+1][3:0], mregs[w*8]};
                sp  = {mregs[w*8+3][3:0], mregs[w*8+2]};
                blk = int'(req_addr[23:12]);
                if (mregs[w*8+1][7] && req_addr[31:24] == mregs[40] && blk >= st && blk <= sp)
                    win = w;
            end
            if (win >= 0) begin
                longint ofs;
                ofs    = {mregs[win*8+5][5:0], mregs[win*8+4]};
                e_hit  = 1; e_win = win;
                e_card = (longint'(req_addr[25:0]) + ofs * 4096) % (longint'(1) << 26);
                e_attr = mregs[win*8+5][6];
                e_ok   = !mregs[win*8+5][7];
                e_blk  = req_write && mregs[win*8+5][7];
                e_we   = req_write && !mregs[win*8+5][7];
            end
        end
        if (cfg_we) mregs[cfg_addr] = cfg_wdata & wmask(int'(cfg_addr));
        #2;
        chk("R9 rsp_valid", 32'(rsp_valid), 32'(e_valid));
        chk("R3 R4 rsp_hit", 32'(rsp_hit), 32'(e_hit));
        chk("R8 rsp_win", 32'(rsp_win), 32'(e_win));
        chk("R5 rsp_card_addr", 32'(rsp_card_addr), 32'(e_card));
        chk("R6 rsp_attr", 32'(rsp_attr), 32'(e_attr));
        chk("R7 rsp_wr_ok", 32'(rsp_wr_ok), 32'(e_ok));
        chk("R7 rsp_wr_blocked", 32'(rsp_wr_blocked), 32'(e_blk));
        chk("R10 card_we", 32'(card_we), 32'(e_we));
        chk("R2 cfg_rdata", 32'(cfg_rdata), 32'(mregs[cfg_addr]));
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        cfg_we = 1; cfg_addr = 6'(a); cfg_wdata = d;
        tick();
        cfg_we = 0;
    endtask

    task automatic rq(input logic w, input logic [31:0] a);
        req_valid = 1; req_write = w; req_addr = a;
        tick();
        req_valid = 0; req_write = 0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mregs[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state of outputs and every register byte
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 0);
        for (int a = 0; a < 64; a++) begin
            cfg_addr = 6'(a);
            #1;
            chk("R1 reset readback", 32'(cfg_rdata), 0);
        end
        cfg_addr = 0;
        rq(0, 32'h0000_0000);   // R1: disabled window 0 covers block 0 but misses
        rq(1, 32'h0000_0000);

        // Window 0: blocks 010..01F, offset 0100h, enabled
        wr(0, 8'h10); wr(1, 8'h80); wr(2, 8'h1F); wr(3, 8'h00);
        wr(4, 8'h00); wr(5, 8'h01);
        rq(0, 32'h0001_0000);   // R4 start edge
        rq(1, 32'h0001_F123);   // R4 stop edge, R10 write strobe
        rq(0, 32'h0000_FFFF);   // below start
        rq(0, 32'h0002_0000);   // above stop
        rq(0, 32'h0101_0000);   // R3 page mismatch
        wr(40, 8'h01);
        rq(0, 32'h0101_0004);   // R3 page now matches
        rq(0, 32'h0001_0004);   // R3 old page misses
        wr(40, 8'h00);

        // Window 1: overlaps window 0, protected, attribute memory
        wr(8, 8'h18); wr(9, 8'h80); wr(10, 8'h30); wr(11, 8'h00);
        wr(12, 8'h22); wr(13, 8'hC3);
        rq(1, 32'h0001_8000);   // R8 window 0 wins the overlap
        rq(0, 32'h0002_5678);   // R6 attribute from window 1
        rq(1, 32'h0002_5678);   // R7 blocked write
        rq(1, 32'h0003_0000);   // R7 at stop edge
        // Window 4: full range, offset 3FFFh wraps mod 2^26 (R5)
        wr(32, 8'h00); wr(33, 8'h8F); wr(34, 8'hFF); wr(35, 8'h0F);
        wr(36, 8'hFF); wr(37, 8'h3F);
        rq(0, 32'h03FF_F000 & 32'h00FF_FFFF);
        rq(1, 32'h00FF_FFFF);
        // R2 reserved bits and addresses
        wr(17, 8'hFF); wr(22, 8'hAA); wr(50, 8'h55); wr(41, 8'h33);
        cfg_addr = 22; tick();
        cfg_addr = 17; tick();
        // Disable window 0: window 1 now answers its overlap (R4 enable)
        wr(1, 8'h00);
        rq(0, 32'h0001_8000);
        // back-to-back requests
        req_valid = 1; req_write = 1; req_addr = 32'h0001_8000; tick();
        req_addr = 32'h0000_1000; tick();
        req_write = 0; req_addr = 32'h00AB_C000; tick();
        req_valid = 0; tick();

        // Pseudo-random mix of register writes and requests
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom) & 32'h7FFF_FFFF;
            cfg_we    = (r % 5) == 0;
            cfg_addr  = 6'($urandom % 48);
            cfg_wdata = 8'($urandom);
            if (cfg_addr == 40) cfg_wdata = {7'b0, cfg_wdata[0]};
            req_valid = (r % 3) != 0;
            req_write = r[8];
            req_addr  = {7'b0, r[9], 4'h0, 8'($urandom % 48), 12'($urandom)};
            tick();
        end
        cfg_we = 0; req_valid = 0;
        tick();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R9 watchdog: got hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule